// File: doc/BRIEF.md
# Branch and Loop Resolution Unit

This unit works out where control goes next for a small 8-bit microcontroller with a 16-bit program counter. Each cycle it receives the opcode byte, up to two operand bytes, the address of the instruction, the accumulator, the carry flag and the value of the working register that a decrement-and-branch instruction names. One clock edge later it presents the next program-counter value, a taken flag, an unsupported-opcode flag and, for decrement-and-branch, the decremented register value with a write-back strobe and the register index.

The handled forms are the unconditional short jump, jumps on accumulator zero or nonzero, jumps on carry set or clear, decrement-and-branch on one of eight registers, and the absolute long jump. Two-byte forms take a signed 8-bit displacement that is added to the address of the following instruction, wrapping modulo 2^16. The decoder sorts each opcode into an enumerated kind, and a `unique case` on that kind selects the condition and the target; the result is held in one output register stage.

Top module: `bju_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, next_pc, taken, reg_we, reg_wdata, reg_sel and unsupported are all zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge and hold their old values until that edge.
- R3: Opcode 80h always jumps; its target is cur_pc + 2 + the sign-extended operand byte opnd1, with any carry beyond 16 bits discarded (displacement FEh at 0015h gives 0015h).
- R4: Opcode 60h jumps only when acc is 00h; opcode 70h jumps only when acc is not 00h; both use the R3 target rule.
- R5: Opcode 40h jumps only when carry is 1; opcode 50h jumps only when carry is 0; both use the R3 target rule.
- R6: Opcodes D8h to DFh decrement register opcode[2:0]: reg_sel equals opcode[2:0], reg_wdata equals reg_val minus 1 modulo 256, reg_we is 1, and the jump, using the R3 target rule, is taken only when reg_wdata is nonzero (reg_val 00h gives FFh and a taken jump).
- R7: A conditional two-byte form that is not taken sets taken to 0 and next_pc to cur_pc + 2.
- R8: Opcode 02h always jumps to the absolute address whose high byte is opnd1 and low byte is opnd2.
- R9: Any other opcode sets taken to 0, reg_we to 0, unsupported to 1 and next_pc to cur_pc + 1 modulo 2^16.
- R10: For every opcode outside D8h to DFh, reg_we, reg_wdata and reg_sel are 0 whatever reg_val holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 8 | Opcode byte of the instruction |
| opnd1 | input | 8 | First operand byte: displacement, or high target byte |
| opnd2 | input | 8 | Second operand byte: low target byte of the long jump |
| cur_pc | input | 16 | Address of the instruction's opcode byte |
| acc | input | 8 | Accumulator value |
| carry | input | 1 | Carry flag |
| reg_val | input | 8 | Value of the register selected by opcode[2:0] |
| next_pc | output | 16 | Next program-counter value |
| taken | output | 1 | High when a transfer of control happens |
| reg_we | output | 1 | Write-back strobe for the decremented register |
| reg_wdata | output | 8 | Decremented register value |
| reg_sel | output | 3 | Index of the register to write back |
| unsupported | output | 1 | High for an opcode this unit does not handle |

## Verification
A wrong decoded kind shows at the ports one cycle after the opcode is applied, as a wrong instruction length in next_pc, a write strobe where none belongs, or a raised unsupported flag. A wrong condition inverts taken and moves next_pc between the target and the fall-through address in the same cycle, so each conditional opcode is applied with both values of its condition. Sign-extension and wrap faults appear only with negative displacements and with addresses near FFFFh, which the vectors cover, including the self-branch and the decrement from 00h.

// File: rtl/bju_pkg.sv
package bju_pkg;

    typedef enum logic [2:0] {
        K_SJMP,
        K_JZ,
        K_JNZ,
        K_JC,
        K_JNC,
        K_DJNZ,
        K_LJMP,
        K_NONE
    } kind_e;

    localparam logic [7:0] OP_SJMP = 8'h80;
    localparam logic [7:0] OP_JZ   = 8'h60;
    localparam logic [7:0] OP_JNZ  = 8'h70;
    localparam logic [7:0] OP_JC   = 8'h40;
    localparam logic [7:0] OP_JNC  = 8'h50;
    localparam logic [7:0] OP_LJMP = 8'h02;
    localparam logic [4:0] OP_DJNZ_HI = 5'b11011;

endpackage

// File: rtl/bju_decode.sv
module bju_decode
    import bju_pkg::*;
#(
    parameter int D_W = 8
) (
    input  logic [D_W-1:0] opcode,
    output kind_e          kind,
    output logic [1:0]     len
);

    always_comb begin
        if (opcode[7:3] == OP_DJNZ_HI) begin
            kind = K_DJNZ;
        end else begin
            unique case (opcode)
                OP_SJMP: kind = K_SJMP;
                OP_JZ:   kind = K_JZ;
                OP_JNZ:  kind = K_JNZ;
                OP_JC:   kind = K_JC;
                OP_JNC:  kind = K_JNC;
                OP_LJMP: kind = K_LJMP;
                default: kind = K_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (kind)
            K_LJMP:  len = 2'd3;
            K_NONE:  len = 2'd1;
            default: len = 2'd2;
        endcase
    end

endmodule

// File: rtl/bju_eval.sv
module bju_eval
    import bju_pkg::*;
#(
    parameter int D_W = 8
) (
    input  kind_e          kind,
    input  logic [D_W-1:0] acc,
    input  logic           carry,
    input  logic [D_W-1:0] reg_val,
    output logic           take,
    output logic           we,
    output logic [D_W-1:0] wdata
);

    logic [D_W-1:0] dec_val;
    logic           acc_zero;

    assign dec_val  = reg_val - D_W'(1);
    assign acc_zero = (acc == '0);

    always_comb begin
        we    = 1'b0;
        wdata = '0;
        unique case (kind)
            K_SJMP: take = 1'b1;
            K_JZ:   take = acc_zero;
            K_JNZ:  take = !acc_zero;
            K_JC:   take = carry;
            K_JNC:  take = !carry;
            K_DJNZ: begin
                we    = 1'b1;
                wdata = dec_val;
                take  = (dec_val != '0);
            end
            K_LJMP: take = 1'b1;
            K_NONE: take = 1'b0;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bju_target.sv
module bju_target
    import bju_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int D_W  = 8
) (
    input  kind_e           kind,
    input  logic [1:0]      len,
    input  logic            take,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [D_W-1:0]  opnd1,
    input  logic [D_W-1:0]  opnd2,
    output logic [PC_W-1:0] next_pc
);

    localparam int EXT_W = PC_W - D_W;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] rel_pc;
    logic [PC_W-1:0] abs_pc;

    assign seq_pc   = cur_pc + PC_W'(len);
    assign disp_ext = {{EXT_W{opnd1[D_W-1]}}, opnd1};
    assign rel_pc   = seq_pc + disp_ext;

    generate
        if (PC_W >= 2 * D_W) begin : g_abs_ext
            assign abs_pc = PC_W'({opnd1, opnd2});
        end else begin : g_abs_trunc
            logic [2*D_W-1:0] abs_full;
            assign abs_full = {opnd1, opnd2};
            assign abs_pc   = abs_full[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        if (!take) begin
            next_pc = seq_pc;
        end else if (kind == K_LJMP) begin
            next_pc = abs_pc;
        end else begin
            next_pc = rel_pc;
        end
    end

endmodule

// File: rtl/bju_unit.sv
module bju_unit
    import bju_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int D_W   = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [D_W-1:0]   opcode,
    input  logic [D_W-1:0]   opnd1,
    input  logic [D_W-1:0]   opnd2,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [D_W-1:0]   acc,
    input  logic             carry,
    input  logic [D_W-1:0]   reg_val,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic             reg_we,
    output logic [D_W-1:0]   reg_wdata,
    output logic [SEL_W-1:0] reg_sel,
    output logic             unsupported
);

    kind_e           kind;
    logic [1:0]      len;
    logic            take;
    logic            we;
    logic [D_W-1:0]  wdata;
    logic [PC_W-1:0] tgt;
    logic [SEL_W-1:0] sel;

    bju_decode #(.D_W(D_W)) u_decode (
        .opcode (opcode),
        .kind   (kind),
        .len    (len)
    );

    bju_eval #(.D_W(D_W)) u_eval (
        .kind    (kind),
        .acc     (acc),
        .carry   (carry),
        .reg_val (reg_val),
        .take    (take),
        .we      (we),
        .wdata   (wdata)
    );

    bju_target #(.PC_W(PC_W), .D_W(D_W)) u_target (
        .kind    (kind),
        .len     (len),
        .take    (take),
        .cur_pc  (cur_pc),
        .opnd1   (opnd1),
        .opnd2   (opnd2),
        .next_pc (tgt)
    );

    assign sel = (kind == K_DJNZ) ? opcode[SEL_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc     <= '0;
            taken       <= 1'b0;
            reg_we      <= 1'b0;
            reg_wdata   <= '0;
            reg_sel     <= '0;
            unsupported <= 1'b0;
        end else begin
            next_pc     <= tgt;
            taken       <= take;
            reg_we      <= we;
            reg_wdata   <= wdata;
            reg_sel     <= sel;
            unsupported <= (kind == K_NONE);
        end
    end

endmodule

// File: rtl/bju_unit_chk.sv
module bju_unit_chk #(
    parameter int PC_W  = 16,
    parameter int D_W   = 8,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [D_W-1:0]   opcode,
    input logic [D_W-1:0]   opnd1,
    input logic [D_W-1:0]   opnd2,
    input logic [PC_W-1:0]  cur_pc,
    input logic [D_W-1:0]   acc,
    input logic             carry,
    input logic [D_W-1:0]   reg_val,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken,
    input logic             reg_we,
    input logic [D_W-1:0]   reg_wdata,
    input logic [SEL_W-1:0] reg_sel,
    input logic             unsupported
);

    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R9
    unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!taken && !reg_we));

    // R6
    wb_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && reg_we) |-> (reg_wdata == D_W'($past(reg_val) - D_W'(1))
                                && reg_sel == $past(opcode[SEL_W-1:0])));

    // R8
    long_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(opcode) == 8'h02) |->
            (taken && next_pc == PC_W'({$past(opnd1), $past(opnd2)})));

    // R7
    fall_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !taken && !unsupported) |->
            (next_pc == PC_W'($past(cur_pc) + PC_W'(2))));

    // R4
    acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(opcode) == 8'h60) |-> (taken == ($past(acc) == '0)));

    // R10
    no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(opcode[7:3]) != 5'b11011) |-> !reg_we);

endmodule

bind bju_unit bju_unit_chk #(.PC_W(PC_W), .D_W(D_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/bju_unit_bench.sv
module bju_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 19;

    typedef struct packed {
        logic [23:0] tag;
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [15:0] pc;
        logic [7:0]  ac;
        logic        cy;
        logic [7:0]  rv;
        logic [15:0] e_pc;
        logic        e_tk;
        logic        e_we;
        logic [7:0]  e_wd;
        logic [2:0]  e_sel;
        logic        e_un;
    } vec_t;

    localparam vec_t VECS [0:N_VEC-1] = '{
        '{"R3",  8'h80, 8'hFE, 8'h00, 16'h0015, 8'h00, 1'b0, 8'h00, 16'h0015, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R3",  8'h80, 8'hF2, 8'h00, 16'h0013, 8'h00, 1'b0, 8'h00, 16'h0007, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R3",  8'h80, 8'h7F, 8'h00, 16'hFFF0, 8'h00, 1'b0, 8'h00, 16'h0071, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R4",  8'h60, 8'h03, 8'h00, 16'h0004, 8'h00, 1'b0, 8'h00, 16'h0009, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R7",  8'h60, 8'h03, 8'h00, 16'h0004, 8'h01, 1'b0, 8'h00, 16'h0006, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R4",  8'h70, 8'h10, 8'h00, 16'h0100, 8'h55, 1'b0, 8'h00, 16'h0112, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R4",  8'h70, 8'h10, 8'h00, 16'h0100, 8'h00, 1'b0, 8'h00, 16'h0102, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R5",  8'h40, 8'h80, 8'h00, 16'h0200, 8'h00, 1'b1, 8'h00, 16'h0182, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R5",  8'h40, 8'h80, 8'h00, 16'h0200, 8'h00, 1'b0, 8'h00, 16'h0202, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R5",  8'h50, 8'h05, 8'h00, 16'h000D, 8'h00, 1'b0, 8'h00, 16'h0014, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R7",  8'h50, 8'h05, 8'h00, 16'h000D, 8'h00, 1'b1, 8'h00, 16'h000F, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R6",  8'hDA, 8'hFC, 8'h00, 16'h0030, 8'h00, 1'b0, 8'h05, 16'h002E, 1'b1, 1'b1, 8'h04, 3'd2, 1'b0},
        '{"R6",  8'hD8, 8'hFC, 8'h00, 16'h0030, 8'h00, 1'b0, 8'h01, 16'h0032, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0},
        '{"R6",  8'hDF, 8'hFE, 8'h00, 16'h0040, 8'h00, 1'b0, 8'h00, 16'h0040, 1'b1, 1'b1, 8'hFF, 3'd7, 1'b0},
        '{"R8",  8'h02, 8'h12, 8'h34, 16'h0000, 8'h00, 1'b0, 8'h00, 16'h1234, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R8",  8'h02, 8'hFF, 8'hFF, 16'h8000, 8'h00, 1'b0, 8'h00, 16'hFFFF, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0},
        '{"R9",  8'h00, 8'h00, 8'h00, 16'h0050, 8'h00, 1'b0, 8'h00, 16'h0051, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1},
        '{"R9",  8'hA5, 8'h00, 8'h00, 16'hFFFF, 8'h00, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1},
        '{"R10", 8'h80, 8'h00, 8'h00, 16'h0010, 8'h00, 1'b0, 8'h09, 16'h0012, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  opnd1 = '0;
    logic [7:0]  opnd2 = '0;
    logic [15:0] cur_pc = '0;
    logic [7:0]  acc = '0;
    logic        carry = 1'b0;
    logic [7:0]  reg_val = '0;
    logic [15:0] next_pc;
    logic        taken;
    logic        reg_we;
    logic [7:0]  reg_wdata;
    logic [2:0]  reg_sel;
    logic        unsupported;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bju_unit u_bju_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .opcode      (opcode),
        .opnd1       (opnd1),
        .opnd2       (opnd2),
        .cur_pc      (cur_pc),
        .acc         (acc),
        .carry       (carry),
        .reg_val     (reg_val),
        .next_pc     (next_pc),
        .taken       (taken),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_sel     (reg_sel),
        .unsupported (unsupported)
    );

    task automatic drive(input vec_t v);
        opcode  = v.op;
        opnd1   = v.b1;
        opnd2   = v.b2;
        cur_pc  = v.pc;
        acc     = v.ac;
        carry   = v.cy;
        reg_val = v.rv;
    endtask

    task automatic check_out(input string req, input logic [15:0] e_pc,
                             input logic e_tk, input logic e_we,
                             input logic [7:0] e_wd, input logic [2:0] e_sel,
                             input logic e_un);
        n_chk++;
        if (next_pc !== e_pc || taken !== e_tk || reg_we !== e_we ||
            reg_wdata !== e_wd || reg_sel !== e_sel || unsupported !== e_un) begin
            n_fail++;
            $display("FAIL %s: got pc=%h tk=%b we=%b wd=%h sel=%0d un=%b, expected pc=%h tk=%b we=%b wd=%h sel=%0d un=%b",
                     req, next_pc, taken, reg_we, reg_wdata, reg_sel, unsupported,
                     e_pc, e_tk, e_we, e_wd, e_sel, e_un);
        end
    endtask

    initial begin
        vec_t v;
        // R1: outputs zero during reset even with busy inputs
        drive(VECS[14]);
        repeat (3) @(negedge clk);
        check_out("R1", 16'h0000, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
        rst_n = 1'b1;
        // R1: first cycle after release still shows reset values
        check_out("R1", 16'h0000, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);

        for (int i = 0; i < N_VEC; i++) begin
            v = VECS[i];
            drive(v);
            @(negedge clk);
            check_out(string'(v.tag), v.e_pc, v.e_tk, v.e_we, v.e_wd, v.e_sel, v.e_un);
        end

        // R2: new inputs do not show before the clock edge
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[15]);
        #1;
        check_out("R2", 16'h0015, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0);
        @(negedge clk);
        check_out("R2", 16'hFFFF, 1'b1, 1'b0, 8'h00, 3'd0, 1'b0);

        // R6: decrement of 02h on register 3 taken, register value chain
        v = '{"R6", 8'hDB, 8'h80, 8'h00, 16'hFFFE, 8'h00, 1'b0, 8'h02,
              16'hFF80, 1'b1, 1'b1, 8'h01, 3'd3, 1'b0};
        drive(v);
        @(negedge clk);
        check_out("R6", v.e_pc, v.e_tk, v.e_we, v.e_wd, v.e_sel, v.e_un);

        // R10: opcode D7h is not a decrement form; reg_val ignored
        v = '{"R10", 8'hD7, 8'h00, 8'h00, 16'h0100, 8'h00, 1'b0, 8'h33,
              16'h0101, 1'b0, 1'b0, 8'h00, 3'd0, 1'b1};
        drive(v);
        @(negedge clk);
        check_out("R10", v.e_pc, v.e_tk, v.e_we, v.e_wd, v.e_sel, v.e_un);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1", 16'h0000, 1'b0, 1'b0, 8'h00, 3'd0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule